// File: doc/BRIEF.md
# Paged Index Register Address Unit

This unit forms the 12-bit data-memory address for a small 4-bit processor core. The data space holds 4,096 nibble-wide words. The unit keeps two 12-bit index pointers, X and Y. Each pointer is a 4-bit page field above an 8-bit in-page offset, and the offset is made of a high nibble and a low nibble. The unit also keeps an 8-bit stack pointer and a 4-bit register pointer. Both of these always address page 0. The address output is a combinational multiplex of the pointer picked by the decoder, so a memory access in a given cycle uses the pointer value held before any update in that cycle.

The decoder updates the pointers through per-field load masks and a shared load data bus. It can also post-increment an index offset by one or two, and it can pre-decrement or post-increment the stack pointer. An index post-increment wraps inside the offset and never carries into the page field. The unit has no flag output, so an offset overflow cannot reach any flag. Every pointer update takes effect on the rising clock edge.

Top module: `paged_addr_unit`

## Requirements
- R1: A synchronous reset clears X, Y, the stack pointer and the register pointer to zero, so the address is 0 for every select value.
- R2: `sel` picks the address source: 0 gives {X page, X offset}, 1 gives {Y page, Y offset}, 2 gives {4'h0, stack pointer}, 3 gives {8'h00, register pointer}.
- R3: Load mask bit 2 loads the page from `ld_data[11:8]`. Bit 1 loads the offset high nibble from `ld_data[7:4]`. Bit 0 loads the offset low nibble from `ld_data[3:0]`. Fields whose mask bit is clear keep their value.
- R4: An index post-increment adds 1 to the offset, or adds 2 when `inc_by2` is 1. The offset wraps modulo 256 and the page field is unchanged.
- R5: The address in the cycle of an increment or load is the value held before that update.
- R6: A nonzero load mask on an index register suppresses an increment requested for the same register in the same cycle.
- R7: `sp_dec` without `sp_ld` is a pre-decrement: in that cycle the address with `sel`=2 is {4'h0, SP-1}, and SP becomes SP-1 modulo 256.
- R8: `sp_inc` without `sp_ld` or `sp_dec` is a post-increment: the address uses the current SP, and SP becomes SP+1 modulo 256.
- R9: For the stack pointer, a load from `ld_data[7:0]` has priority over a decrement, and a decrement has priority over an increment.
- R10: `rp_ld` loads the register pointer from `ld_data[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 2 | Address source select |
| ld_data | input | 12 | Shared load value |
| x_ld_mask | input | 3 | X field load mask {page, high, low} |
| y_ld_mask | input | 3 | Y field load mask {page, high, low} |
| x_inc | input | 1 | Post-increment the X offset |
| y_inc | input | 1 | Post-increment the Y offset |
| inc_by2 | input | 1 | Increment step is 2 instead of 1 |
| sp_ld | input | 1 | Load the stack pointer |
| sp_dec | input | 1 | Pre-decrement the stack pointer |
| sp_inc | input | 1 | Post-increment the stack pointer |
| rp_ld | input | 1 | Load the register pointer |
| addr | output | 12 | Data-memory address |

## Verification
Directed cases drive each offset across its top boundary with both step sizes. These cases separate a correct modulo-256 wrap from a carry that leaks into the page field. They also move the stack pointer through 00 and FF in both directions, which exposes an unwrapped or misapplied decrement. Other directed cases apply a partial mask together with an increment, and a stack load together with a decrement. These show whether the priorities hold and whether unmasked nibbles are kept. A long run of seeded random selects, masks and update requests then checks every cycle against a bench model. Because the select rotates at random, a corruption in a register that is not currently selected shows up when that register is selected later.

// File: rtl/pau_pkg.sv
package pau_pkg;
    typedef enum logic [1:0] {
        PSEL_IDX_X = 2'd0,
        PSEL_IDX_Y = 2'd1,
        PSEL_STACK = 2'd2,
        PSEL_REGP  = 2'd3
    } ptr_sel_e;

    localparam int MASK_PAGE = 2;
    localparam int MASK_HI   = 1;
    localparam int MASK_LO   = 0;
endpackage

// File: rtl/pau_index_reg.sv
module pau_index_reg #(
    parameter int PAGE_W = 4,
    parameter int OFF_W  = 8,
    localparam int REG_W = PAGE_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ld_mask,
    input  logic [REG_W-1:0] ld_data,
    input  logic             inc,
    input  logic             inc_by2,
    output logic [REG_W-1:0] q
);
    import pau_pkg::*;
    localparam int NIB_W = OFF_W / 2;

    logic [PAGE_W-1:0] page_q;
    logic [NIB_W-1:0]  hi_q, lo_q;
    logic [OFF_W-1:0]  off_next;

    always_comb begin
        off_next = {hi_q, lo_q} + (inc_by2 ? OFF_W'(2) : OFF_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else if (|ld_mask) begin
            if (ld_mask[MASK_PAGE]) page_q <= ld_data[REG_W-1:OFF_W];
            if (ld_mask[MASK_HI])   hi_q   <= ld_data[OFF_W-1:NIB_W];
            if (ld_mask[MASK_LO])   lo_q   <= ld_data[NIB_W-1:0];
        end else if (inc) begin
            {hi_q, lo_q} <= off_next;
        end
    end

    assign q = {page_q, hi_q, lo_q};
endmodule

// File: rtl/pau_stack_ptr.sv
module pau_stack_ptr #(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld,
    input  logic [SP_W-1:0] ld_val,
    input  logic            dec,
    input  logic            inc,
    output logic [SP_W-1:0] q,
    output logic [SP_W-1:0] acc
);
    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_minus;

    assign sp_minus = sp_q - SP_W'(1);

    always_ff @(posedge clk) begin
        if (rst)      sp_q <= '0;
        else if (ld)  sp_q <= ld_val;
        else if (dec) sp_q <= sp_minus;
        else if (inc) sp_q <= sp_q + SP_W'(1);
    end

    assign q   = sp_q;
    assign acc = (dec && !ld) ? sp_minus : sp_q;
endmodule

// File: rtl/paged_addr_unit.sv
module paged_addr_unit #(
    parameter int PAGE_W = 4,
    parameter int OFF_W  = 8,
    parameter int RP_W   = 4,
    localparam int ADDR_W = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] ld_data,
    input  logic [2:0]        x_ld_mask,
    input  logic [2:0]        y_ld_mask,
    input  logic              x_inc,
    input  logic              y_inc,
    input  logic              inc_by2,
    input  logic              sp_ld,
    input  logic              sp_dec,
    input  logic              sp_inc,
    input  logic              rp_ld,
    output logic [ADDR_W-1:0] addr
);
    import pau_pkg::*;

    logic [ADDR_W-1:0] x_val, y_val;
    logic [OFF_W-1:0]  sp_val, sp_acc;
    logic [RP_W-1:0]   rp_val;
    ptr_sel_e          sel_e;

    pau_index_reg #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_ix (
        .clk(clk), .rst(rst), .ld_mask(x_ld_mask), .ld_data(ld_data),
        .inc(x_inc), .inc_by2(inc_by2), .q(x_val)
    );

    pau_index_reg #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_iy (
        .clk(clk), .rst(rst), .ld_mask(y_ld_mask), .ld_data(ld_data),
        .inc(y_inc), .inc_by2(inc_by2), .q(y_val)
    );

    pau_stack_ptr #(.SP_W(OFF_W)) u_sp (
        .clk(clk), .rst(rst), .ld(sp_ld), .ld_val(ld_data[OFF_W-1:0]),
        .dec(sp_dec), .inc(sp_inc), .q(sp_val), .acc(sp_acc)
    );

    always_ff @(posedge clk) begin
        if (rst)        rp_val <= '0;
        else if (rp_ld) rp_val <= ld_data[RP_W-1:0];
    end

    assign sel_e = ptr_sel_e'(sel);

    always_comb begin
        unique case (sel_e)
            PSEL_IDX_X: addr = x_val;
            PSEL_IDX_Y: addr = y_val;
            PSEL_STACK: addr = {{PAGE_W{1'b0}}, sp_acc};
            PSEL_REGP:  addr = {{(ADDR_W-RP_W){1'b0}}, rp_val};
            default:    addr = '0;
        endcase
    end
endmodule

// File: rtl/pau_checker.sv
module pau_checker (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  sel,
    input logic [11:0] ld_data,
    input logic [2:0]  x_ld_mask,
    input logic        x_inc,
    input logic        inc_by2,
    input logic        sp_ld,
    input logic        sp_dec,
    input logic [11:0] x_val,
    input logic [7:0]  sp_val,
    input logic [11:0] addr
);
    AST_STACK_PAGE0: assert property (@(posedge clk) disable iff (rst)
        sel == 2'd2 |-> addr[11:8] == 4'h0); // R2
    AST_REGP_PAGE0: assert property (@(posedge clk) disable iff (rst)
        sel == 2'd3 |-> addr[11:4] == 8'h00); // R2
    AST_FULL_LOAD: assert property (@(posedge clk) disable iff (rst)
        x_ld_mask == 3'b111 |=> x_val == $past(ld_data)); // R3
    AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (x_inc && x_ld_mask == 3'b000) |=> x_val[11:8] == $past(x_val[11:8])); // R4
    AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (rst)
        (x_inc && x_ld_mask == 3'b000) |=>
        x_val[7:0] == 8'($past(x_val[7:0]) + ($past(inc_by2) ? 8'd2 : 8'd1))); // R4
    AST_LOAD_OVER_INC: assert property (@(posedge clk) disable iff (rst)
        (x_inc && x_ld_mask[0]) |=> x_val[3:0] == $past(ld_data[3:0])); // R6
    AST_SP_PREDEC: assert property (@(posedge clk) disable iff (rst)
        (sp_dec && !sp_ld) |=> sp_val == 8'($past(sp_val) - 8'd1)); // R7
    AST_SP_LOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
        sp_ld |=> sp_val == $past(ld_data[7:0])); // R9
endmodule

bind paged_addr_unit pau_checker u_chk (.*);

// File: tb/paged_addr_unit_bench.sv
module paged_addr_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  sel;
    logic [11:0] ld_data;
    logic [2:0]  x_ld_mask, y_ld_mask;
    logic        x_inc, y_inc, inc_by2, sp_ld, sp_dec, sp_inc, rp_ld;
    logic [11:0] addr;

    logic [11:0] mx, my;
    logic [7:0]  msp;
    logic [3:0]  mrp;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    paged_addr_unit u_paged_addr_unit (.*);

    function automatic logic [11:0] exp_addr();
        case (sel)
            2'd0: return mx;
            2'd1: return my;
            2'd2: return {4'h0, (sp_dec && !sp_ld) ? 8'(msp - 8'd1) : msp};
            default: return {8'h00, mrp};
        endcase
    endfunction

    function automatic logic [11:0] upd_idx(logic [11:0] v, logic [2:0] m, logic inc);
        logic [11:0] r = v;
        if (m != 3'b000) begin
            if (m[2]) r[11:8] = ld_data[11:8];
            if (m[1]) r[7:4]  = ld_data[7:4];
            if (m[0]) r[3:0]  = ld_data[3:0];
        end else if (inc) begin
            r[7:0] = 8'(v[7:0] + (inc_by2 ? 8'd2 : 8'd1));
        end
        return r;
    endfunction

    task automatic idle();
        x_ld_mask = 3'b000; y_ld_mask = 3'b000; x_inc = 0; y_inc = 0;
        inc_by2 = 0; sp_ld = 0; sp_dec = 0; sp_inc = 0; rp_ld = 0;
        ld_data = 12'h000;
    endtask

    task automatic check(string tag, logic [11:0] exp);
        checks++;
        if (addr !== exp) begin
            errors++;
            $display("FAIL %s: addr=%h expected=%h", tag, addr, exp);
        end
    endtask

    // inputs are set at the falling edge; check, clock, update model
    task automatic step(string tag);
        #1 check(tag, exp_addr());
        @(posedge clk);
        mx = upd_idx(mx, x_ld_mask, x_inc);
        my = upd_idx(my, y_ld_mask, y_inc);
        if (sp_ld) msp = ld_data[7:0];
        else if (sp_dec) msp = 8'(msp - 8'd1);
        else if (sp_inc) msp = 8'(msp + 8'd1);
        if (rp_ld) mrp = ld_data[3:0];
        @(negedge clk);
        idle();
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        idle();
        sel = 2'd0; rst = 1'b1;
        mx = '0; my = '0; msp = '0; mrp = '0;
        repeat (3) @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            #1 check("R1 reset", 12'h000);
        end
        rst = 1'b0;
        @(negedge clk);

        // R3 full and partial loads
        sel = 2'd0; x_ld_mask = 3'b111; ld_data = 12'hABC; step("R3 full load");
        sel = 2'd0; x_ld_mask = 3'b010; ld_data = 12'h5F0; step("R3 hi nibble");
        sel = 2'd0; step("R3 hi nibble result");
        sel = 2'd1; y_ld_mask = 3'b101; ld_data = 12'h7E3; step("R3 page+lo");
        sel = 2'd1; step("R3 page+lo result");
        // R4 wrap and R5 pre-update address
        sel = 2'd0; x_ld_mask = 3'b011; ld_data = 12'h0FF; step("R3 offset load");
        sel = 2'd0; x_inc = 1; step("R5 old value during inc");
        sel = 2'd0; step("R4 wrap by 1");
        sel = 2'd0; x_ld_mask = 3'b011; ld_data = 12'h0FE; step("R3 offset load");
        sel = 2'd0; x_inc = 1; inc_by2 = 1; step("R5 old value during inc2");
        sel = 2'd0; step("R4 wrap by 2 from FE");
        sel = 2'd0; x_ld_mask = 3'b011; ld_data = 12'h0FF; step("R3 offset load");
        sel = 2'd0; x_inc = 1; inc_by2 = 1; step("R4 inc2 from FF");
        sel = 2'd0; step("R4 result 01 same page");
        // R6 load beats increment
        sel = 2'd1; y_ld_mask = 3'b001; y_inc = 1; ld_data = 12'h009; step("R6 load with inc");
        sel = 2'd1; step("R6 result");
        // R7 / R8 / R9 stack
        sel = 2'd2; sp_dec = 1; step("R7 predec from 00");
        sel = 2'd2; step("R7 SP now FF");
        sel = 2'd2; sp_inc = 1; step("R8 postinc from FF");
        sel = 2'd2; step("R8 SP now 00");
        sel = 2'd2; sp_ld = 1; sp_dec = 1; ld_data = 12'h040; step("R9 load over dec");
        sel = 2'd2; sp_dec = 1; sp_inc = 1; step("R9 dec over inc");
        sel = 2'd2; step("R9 result");
        // R10 register pointer
        sel = 2'd3; rp_ld = 1; ld_data = 12'hFFD; step("R10 rp load");
        sel = 2'd3; step("R10 rp result");

        for (int i = 0; i < 3000; i++) begin
            sel = 2'($urandom % 4);
            ld_data = 12'($urandom);
            x_ld_mask = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
            y_ld_mask = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
            x_inc = 1'($urandom); y_inc = 1'($urandom); inc_by2 = 1'($urandom);
            sp_ld = ($urandom % 6 == 0); sp_dec = 1'($urandom); sp_inc = 1'($urandom);
            rp_ld = ($urandom % 4 == 0);
            step("R2 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule